// File: doc/BRIEF.md
# Internal-Access Show-Cycle Bus Driver

This block copies accesses that the processor core makes on its on-chip bus onto an external bus, so that debug and emulation equipment attached outside the chip can watch them. Each access arrives as a descriptor on a valid/ready input stream. A descriptor carries the address, the data, the read/write direction, the instruction/data kind, the privilege level, a trace/reservation qualifier, and a burst continuation flag. A separate select input marks a descriptor as DMA-initiated. For such a descriptor the upper three type bits come from a programmable function-code input and not from the access attributes.

For each shown access the block drives an address phase of exactly one clock. For data-kind accesses it then drives a data phase of exactly one clock. No transfer acknowledge is awaited. The block builds a four-bit address-type code and decodes it onto two active-low strobes, one for program trace and one for reservation. A start strobe marks the address phase.

Back-pressure: `req_ready` is high only while no show cycle is in progress. A descriptor is taken on a clock edge where `req_valid` and `req_ready` are both high. While a cycle runs, a pending descriptor waits with `req_valid` held high and its fields held stable until `req_ready` returns.

Top module: `show_cycle_driver`

## Requirements
- R1: `req_ready` is high only while both phase outputs are low and no cycle is pending. A descriptor offered during a show cycle is not taken until the bus returns to idle, and it is then shown normally.
- R2: In the clock after a non-continuation descriptor is taken, `addr_phase` and `start` are high for exactly one clock. During that clock `ext_addr` carries the descriptor's address.
- R3: When type bit 2 is 1 (data access), the clock after the address phase has `data_phase` high for exactly one clock with `ext_data` carrying the descriptor's data. No acknowledge input exists or is waited for.
- R4: When type bit 2 is 0 (instruction access), there is no data phase, and the bus is idle in the clock after the address phase.
- R5: A descriptor with `req_cont`=1 (a later beat of a burst) is taken while idle and produces no address or data phase. Only the first beat of a burst (`req_cont`=0) is shown.
- R6: For core accesses `ext_type` is {bit3=`req_qual_n`, bit2=~`req_instr`, bit1=`req_user`, bit0=0}. Bit 1 is 1 for user mode and 0 for supervisor mode.
- R7: For DMA accesses (`req_dma`=1) `ext_type` bit 0 is 1, and bits 1, 2 and 3 equal `dma_fc[0]`, `dma_fc[1]` and `dma_fc[2]`.
- R8: `ptrace_n` is low only during an address phase whose type has bits 0, 2 and 3 all 0.
- R9: `resv_n` is low only during an address phase whose type has bit 0 = 0, bit 2 = 1 and bit 3 = 0. It is high for every DMA cycle.
- R10: Outside an active phase, `ext_addr` and `ext_data` are 0, `ext_type` is 4'hF, `start` is low, and both strobes are high. `ext_data` is also 0 during the address phase, and `ext_addr` is 0 during the data phase.
- R11: `ext_write` equals the descriptor's `req_write` during both phases of its cycle (1 = write, 0 = read), and it is 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Descriptor offered |
| req_ready | output | 1 | Descriptor may be taken (bus idle) |
| req_addr | input | AW | Access address |
| req_data | input | DW | Access data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_qual_n | input | 1 | 0 = flag trace (instruction) or reservation (data) |
| req_cont | input | 1 | 1 = later beat of a burst, not shown |
| req_dma | input | 1 | 1 = DMA-initiated descriptor |
| dma_fc | input | 3 | Programmable type bits 1..3 for DMA descriptors |
| ext_addr | output | AW | Shown address |
| ext_data | output | DW | Shown data |
| ext_type | output | 4 | Address-type code |
| ext_write | output | 1 | Direction of the shown cycle |
| addr_phase | output | 1 | Address phase valid |
| data_phase | output | 1 | Data phase valid |
| start | output | 1 | Special-cycle start strobe |
| ptrace_n | output | 1 | Active-low program-trace indicator |
| resv_n | output | 1 | Active-low reservation indicator |

## Verification
Random descriptors mix core and DMA origin, all privilege, kind and qualifier values, random directions, and random continuation beats. This separates the address-only sequence from the address-plus-data sequence, and it shows whether the strobes follow type bits 0, 2 and 3 or only some of them. Directed cases isolate situations that random stimulus hits only rarely. These are a DMA function code of zero, which must not raise either strobe, a burst whose later beats must vanish, and a descriptor offered during a running cycle, which must wait and then appear intact. Idle gaps of random length between descriptors confirm the idle values of every output.

// File: rtl/show_cycle_pkg.sv
package show_cycle_pkg;
  localparam int TYPE_W = 4;
  localparam int FC_W   = TYPE_W - 1;
  localparam logic [TYPE_W-1:0] TYPE_IDLE = '1;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_ADDR = 2'd1,
    SC_DATA = 2'd2
  } sc_state_e;

  // positions inside the type code
  localparam int TB_ORIGIN = 0;
  localparam int TB_PRIV   = 1;
  localparam int TB_KIND   = 2;
  localparam int TB_QUAL   = 3;
endpackage

// File: rtl/sc_type_encode.sv
module sc_type_encode
  import show_cycle_pkg::*;
(
  input  logic            is_dma,
  input  logic [FC_W-1:0] fc,
  input  logic            user,
  input  logic            instr,
  input  logic            qual_n,
  output logic [TYPE_W-1:0] type_code
);
  logic [FC_W-1:0] core_bits;

  always_comb begin
    core_bits[TB_PRIV-1] = user;
    core_bits[TB_KIND-1] = ~instr;
    core_bits[TB_QUAL-1] = qual_n;
  end

  always_comb begin
    type_code[TB_ORIGIN] = is_dma;
    type_code[TYPE_W-1:1] = is_dma ? fc : core_bits;
  end
endmodule

// File: rtl/sc_strobe_decode.sv
module sc_strobe_decode
  import show_cycle_pkg::*;
(
  input  logic              addr_phase,
  input  logic [TYPE_W-1:0] type_code,
  output logic              ptrace_n,
  output logic              resv_n
);
  logic core_flagged;

  always_comb begin
    core_flagged = addr_phase && !type_code[TB_ORIGIN] && !type_code[TB_QUAL];
    ptrace_n = !(core_flagged && !type_code[TB_KIND]);
    resv_n   = !(core_flagged &&  type_code[TB_KIND]);
  end
endmodule

// File: rtl/sc_phase_seq.sv
module sc_phase_seq
  import show_cycle_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_cont,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_data,
  input  logic              req_write,
  input  logic [TYPE_W-1:0] req_type,
  output logic [AW-1:0]     ext_addr,
  output logic [DW-1:0]     ext_data,
  output logic [TYPE_W-1:0] ext_type,
  output logic              ext_write,
  output logic              addr_phase,
  output logic              data_phase
);
  sc_state_e         state_q, state_d;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     data_q;
  logic              write_q;
  logic [TYPE_W-1:0] type_q;
  logic              take;

  assign req_ready = (state_q == SC_IDLE);
  assign take      = req_valid && req_ready && !req_cont;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SC_IDLE: if (take) state_d = SC_ADDR;
      SC_ADDR: state_d = type_q[TB_KIND] ? SC_DATA : SC_IDLE;
      SC_DATA: state_d = SC_IDLE;
      default: state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      write_q <= 1'b0;
      type_q  <= TYPE_IDLE;
    end else begin
      state_q <= state_d;
      if (take) begin
        addr_q  <= req_addr;
        data_q  <= req_data;
        write_q <= req_write;
        type_q  <= req_type;
      end
    end
  end

  always_comb begin
    addr_phase = (state_q == SC_ADDR);
    data_phase = (state_q == SC_DATA);
    ext_addr   = addr_phase ? addr_q : '0;
    ext_type   = addr_phase ? type_q : TYPE_IDLE;
    ext_data   = data_phase ? data_q : '0;
    ext_write  = (addr_phase || data_phase) ? write_q : 1'b0;
  end
endmodule

// File: rtl/show_cycle_driver.sv
module show_cycle_driver
  import show_cycle_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_data,
  input  logic              req_write,
  input  logic              req_instr,
  input  logic              req_user,
  input  logic              req_qual_n,
  input  logic              req_cont,
  input  logic              req_dma,
  input  logic [2:0]        dma_fc,
  output logic [AW-1:0]     ext_addr,
  output logic [DW-1:0]     ext_data,
  output logic [3:0]        ext_type,
  output logic              ext_write,
  output logic              addr_phase,
  output logic              data_phase,
  output logic              start,
  output logic              ptrace_n,
  output logic              resv_n
);
  logic [TYPE_W-1:0] enc_type;

  sc_type_encode u_enc (
    .is_dma    (req_dma),
    .fc        (dma_fc),
    .user      (req_user),
    .instr     (req_instr),
    .qual_n    (req_qual_n),
    .type_code (enc_type)
  );

  sc_phase_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_cont   (req_cont),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .req_write  (req_write),
    .req_type   (enc_type),
    .ext_addr   (ext_addr),
    .ext_data   (ext_data),
    .ext_type   (ext_type),
    .ext_write  (ext_write),
    .addr_phase (addr_phase),
    .data_phase (data_phase)
  );

  sc_strobe_decode u_dec (
    .addr_phase (addr_phase),
    .type_code  (ext_type),
    .ptrace_n   (ptrace_n),
    .resv_n     (resv_n)
  );

  assign start = addr_phase;
endmodule

// File: rtl/show_cycle_checker.sv
module show_cycle_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic [AW-1:0] ext_addr,
  input logic [DW-1:0] ext_data,
  input logic [3:0]    ext_type,
  input logic          ext_write,
  input logic          addr_phase,
  input logic          data_phase,
  input logic          start,
  input logic          ptrace_n,
  input logic          resv_n
);
  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase || data_phase) |-> !req_ready);

  assert_addr_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> !addr_phase);

  assert_start_with_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start == addr_phase);

  assert_data_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |=> !data_phase);

  assert_data_after_dataaddr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |-> ($past(addr_phase) && $past(ext_type[2])));

  assert_instr_no_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !ext_type[2]) |=> !data_phase);

  assert_ptrace_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ptrace_n |-> (addr_phase && ext_type[0] == 1'b0 && ext_type[2] == 1'b0 && ext_type[3] == 1'b0));

  assert_resv_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !resv_n |-> (addr_phase && ext_type[0] == 1'b0 && ext_type[2] && ext_type[3] == 1'b0));

  assert_idle_values_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_phase || data_phase) |-> (ext_addr == '0 && ext_data == '0 && ext_type == 4'hF
                                     && ptrace_n && resv_n && !start));

  assert_write_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |-> (ext_write == $past(ext_write)));
endmodule

bind show_cycle_driver show_cycle_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .ext_addr   (ext_addr),
  .ext_data   (ext_data),
  .ext_type   (ext_type),
  .ext_write  (ext_write),
  .addr_phase (addr_phase),
  .data_phase (data_phase),
  .start      (start),
  .ptrace_n   (ptrace_n),
  .resv_n     (resv_n)
);

// File: tb/sim_show_cycle_driver.sv
`timescale 1ns/1ps
module sim_show_cycle_driver;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_write = 1'b0, req_instr = 1'b0, req_user = 1'b0, req_qual_n = 1'b1;
  logic req_cont = 1'b0, req_dma = 1'b0;
  logic [2:0] dma_fc = '0;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_data;
  logic [3:0] ext_type;
  logic ext_write, addr_phase, data_phase, start, ptrace_n, resv_n;

  int n_chk = 0;
  int n_bad = 0;
  int seed = 17;

  always #10 clk = ~clk;

  show_cycle_driver #(.AW(AW), .DW(DW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_type(input logic dma, input logic [2:0] fc,
                                          input logic user, input logic instr, input logic q);
    return dma ? {fc, 1'b1} : {q, ~instr, user, 1'b0};
  endfunction

  function automatic logic exp_ptr_n(input logic [3:0] t);
    return !(t[0] == 1'b0 && t[2] == 1'b0 && t[3] == 1'b0);
  endfunction

  function automatic logic exp_rsv_n(input logic [3:0] t);
    return !(t[0] == 1'b0 && t[2] == 1'b1 && t[3] == 1'b0);
  endfunction

  task automatic check_idle(input string ctx);
    chk(!addr_phase && !data_phase, {"R10 phases idle ", ctx}, {addr_phase, data_phase}, 0);
    chk(ext_addr == '0 && ext_data == '0, {"R10 addr/data idle ", ctx}, ext_addr ^ ext_data, 0);
    chk(ext_type == 4'hF, {"R10 type idle ", ctx}, ext_type, 4'hF);
    chk(ptrace_n && resv_n && !start, {"R10 strobes idle ", ctx}, {ptrace_n, resv_n, start}, 3'b110);
    chk(!ext_write, {"R11 write idle ", ctx}, ext_write, 0);
    chk(req_ready, {"R1 ready idle ", ctx}, req_ready, 1);
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic w,
                      input logic ins, input logic usr, input logic q, input logic cn,
                      input logic dm, input logic [2:0] fc);
    req_addr = a; req_data = d; req_write = w; req_instr = ins; req_user = usr;
    req_qual_n = q; req_cont = cn; req_dma = dm; dma_fc = fc;
  endtask

  // checks address phase for currently loaded descriptor fields (passed in)
  task automatic check_addr(input logic [AW-1:0] a, input logic w, input logic [3:0] t);
    chk(addr_phase && start, "R2 addr phase+start", {addr_phase, start}, 2'b11);
    chk(ext_addr == a, "R2 ext_addr", ext_addr, a);
    chk(ext_type == t, t[0] ? "R7 dma type" : "R6 core type", ext_type, t);
    chk(ptrace_n == exp_ptr_n(t), "R8 ptrace_n", ptrace_n, exp_ptr_n(t));
    chk(resv_n == exp_rsv_n(t), "R9 resv_n", resv_n, exp_rsv_n(t));
    chk(ext_write == w, "R11 write in addr", ext_write, w);
    chk(ext_data == '0 && !data_phase, "R10 no data in addr", ext_data, 0);
    chk(!req_ready, "R1 busy not ready", req_ready, 0);
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic w,
                      input logic ins, input logic usr, input logic q, input logic cn,
                      input logic dm, input logic [2:0] fc);
    logic [3:0] t;
    t = exp_type(dm, fc, usr, ins, q);
    @(negedge clk);
    load(a, d, w, ins, usr, q, cn, dm, fc);
    req_valid = 1'b1;
    chk(req_ready, "R1 ready before take", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (cn) begin
      chk(!addr_phase && !data_phase, "R5 continuation not shown", {addr_phase, data_phase}, 0);
      chk(req_ready, "R5 ready after continuation", req_ready, 1);
    end else begin
      check_addr(a, w, t);
      @(negedge clk);
      chk(!addr_phase, "R2 addr one clock", addr_phase, 0);
      if (t[2]) begin
        chk(data_phase, "R3 data phase", data_phase, 1);
        chk(ext_data == d, "R3 ext_data", ext_data, d);
        chk(ext_addr == '0 && ext_type == 4'hF, "R10 addr idle in data", ext_addr, 0);
        chk(ext_write == w, "R11 write in data", ext_write, w);
        chk(ptrace_n && resv_n && !start, "R10 strobes in data", {ptrace_n, resv_n, start}, 3'b110);
        chk(!req_ready, "R1 busy in data", req_ready, 0);
        @(negedge clk);
        chk(!data_phase, "R3 data one clock", data_phase, 0);
      end else begin
        chk(!data_phase, "R4 instr no data", data_phase, 0);
      end
    end
    check_idle("after cycle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check_idle("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("after reset");

    // directed: core instruction with trace, supervisor
    send(32'h0000_1000, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000);
    // core data reservation, user, write
    send(32'hDEAD_0004, 32'hCAFE_F00D, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
    // core data read, no qualifier
    send(32'h1234_5678, 32'h8765_4321, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000);
    // DMA with zero function code: instruction-like, strobes high (R7, R8, R9)
    send(32'hAAAA_0000, 32'h1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b000);
    // DMA data-kind with reservation-like bits: resv_n stays high
    send(32'hBBBB_0000, 32'h5555_AAAA, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'b010);
    // burst: first beat shown, continuation beats suppressed (R5)
    send(32'h0000_2000, 32'h1111_1111, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000);
    send(32'h0000_2004, 32'h2222_2222, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000);
    send(32'h0000_2008, 32'h3333_3333, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000);

    // held request during a running cycle (R1)
    @(negedge clk);
    load(32'hC0DE_0000, 32'h0BAD_BEEF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000);
    req_valid = 1'b1;
    @(negedge clk);
    check_addr(32'hC0DE_0000, 1'b1, 4'b1100);
    load(32'hF00D_0000, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
    @(negedge clk);
    chk(data_phase && ext_data == 32'h0BAD_BEEF, "R1 first cycle intact while held", ext_data, 32'h0BAD_BEEF);
    chk(!req_ready, "R1 held request waits", req_ready, 0);
    @(negedge clk);
    chk(req_ready && !addr_phase && !data_phase, "R1 ready returns", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check_addr(32'hF00D_0000, 1'b0, 4'b0010);
    @(negedge clk);
    chk(!data_phase, "R4 held instr no data", data_phase, 0);
    check_idle("after held");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic dm, cn;
      dm = ($urandom % 4) == 0;
      cn = ($urandom % 5) == 0;
      send($urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), cn, dm, 3'($urandom));
      for (int g = 0; g < int'($urandom % 3); g++) begin
        @(negedge clk);
        check_idle("gap");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule